// File: doc/BRIEF.md
# Compressed Mode Stream Sequencer

This block sits between an instruction halfword source and a decoder in a front end that mixes standard 32-bit instructions with 16-bit compressed ones. Halfwords arrive one at a time over a valid/ready handshake, most significant halfword first. In this description bit 0 is the most significant bit of a halfword and bit 15 the least significant. The sequencer keeps track of the current encoding mode. It pairs halfwords into 32-bit instructions, or it passes a single halfword on as a compressed instruction. Each emitted instruction carries a two-bit format tag, which a downstream decoder uses to choose its field layout.

A 5-bit major opcode is supplied as an input, so software or a configuration register can change it. In 32-bit mode, a halfword whose top five bits equal this opcode, arriving at an instruction boundary, is a compressed instruction with an 11-bit payload. Its last bit (M) decides whether the following stream is read as 16-bit compressed instructions.

In 16-bit mode the first bit (N) and the last bit (M) act together as a control pair. One combination stays in 16-bit mode and one returns to 32-bit mode for good. A third returns for exactly one 32-bit instruction. The fourth marks an immediate-format instruction and leaves the mode unchanged. A 3-bit compressed major field, bits 5 to 7, exempts two of its values from every mode change. A synchronous flush puts the block back into 32-bit mode.

Top module: `cmode_seq`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the mode is 32-bit and no halfword is held.
- R2: In 32-bit mode, two accepted halfwords form one instruction with the first halfword in out_insn[31:16]. It is presented with out_fmt = 0 in the cycle after the second halfword is accepted. Gaps in in_valid between the halves are allowed.
- R3: In 32-bit mode, at an instruction boundary, a halfword whose bits 0-4 (in_half[15:11]) equal major_op is emitted alone with out_fmt = 1 and out_insn[31:16] = 0. If in_half[0] (M) is 1, the following instructions are read in 16-bit mode. If it is 0, the mode stays 32-bit.
- R4: In 16-bit mode each halfword is emitted alone. With N = in_half[15] and M = in_half[0], NM = 01 emits out_fmt = 2 and stays in 16-bit mode. NM = 00 emits out_fmt = 2 and returns to 32-bit mode permanently.
- R5: In 16-bit mode NM = 10 emits out_fmt = 2. The next two halfwords then form exactly one 32-bit instruction, even if they match major_op, and after it the stream is back in 16-bit mode.
- R6: In 16-bit mode NM = 11 emits out_fmt = 3 and the mode stays 16-bit.
- R7: When the compressed major field in_half[10:8] is 001 or 111, N and M cause no mode change. In 16-bit mode such a halfword is emitted with out_fmt = 2, and the mode stays 16-bit. In 32-bit entry form it is emitted with out_fmt = 1, and the mode stays 32-bit.
- R8: A halfword that completes a 32-bit instruction is never taken as a compressed one, even when its top five bits equal major_op.
- R9: While flush is 1, in_ready is 0. In the next cycle out_valid is 0, any held first halfword is gone, and the mode is 32-bit.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_insn and out_fmt keep their values.
- R11: major_op is read when each halfword is accepted, so a new value changes at once which halfwords count as compressed entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Synchronous flush: drop output and partial instruction, return to 32-bit mode |
| major_op | input | 5 | Programmable major opcode marking a compressed entry halfword |
| in_valid | input | 1 | Input halfword valid |
| in_half | input | 16 | Input halfword, bit 15 of the port is bit 0 of the instruction |
| in_ready | output | 1 | Sequencer can accept a halfword |
| out_valid | output | 1 | Output instruction valid |
| out_insn | output | 32 | Instruction: two halfwords, or one halfword zero-extended |
| out_fmt | output | 2 | Format tag: 0 32-bit, 1 compressed entry, 2 compressed, 3 compressed immediate |
| out_ready | input | 1 | Downstream accepts the output instruction |

## Verification
The bench builds the block with its default widths: a 16-bit halfword, a 5-bit major opcode and a 3-bit compressed major field. With these widths the field positions match the control bits described above. Because major_op is a port and not a parameter, the bench can change it during the run and reach R11 without a second build. A long randomized stretch biases halfwords toward the programmed opcode. It also mixes in stalls and rare flushes, so that mode changes meet backpressure and flushes arrive in the middle of an instruction.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;

    typedef enum logic [1:0] {
        MODE_STD = 2'd0,
        MODE_CMP = 2'd1,
        MODE_ONE = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        FMT_W32  = 2'd0,
        FMT_C10  = 2'd1,
        FMT_C16  = 2'd2,
        FMT_CIMM = 2'd3
    } fmt_e;

endpackage

// File: rtl/cmseq_classify.sv
module cmseq_classify
    import cmseq_pkg::*;
#(
    parameter int HW_W   = 16,
    parameter int OPC_W  = 5,
    parameter int CMAJ_W = 3
) (
    input  logic [HW_W-1:0]  half,
    input  mode_e            mode,
    input  logic             pend,
    input  logic [OPC_W-1:0] major_op,
    output logic             single,
    output fmt_e             fmt,
    output mode_e            nxt_mode
);

    localparam int OPC_LSB  = HW_W - OPC_W;
    localparam int CMAJ_MSB = OPC_LSB - 1;
    localparam int CMAJ_LSB = OPC_LSB - CMAJ_W;

    logic              n_bit;
    logic              m_bit;
    logic              exempt;
    logic              entry_hit;
    logic [CMAJ_W-1:0] cmaj;

    always_comb begin
        n_bit     = half[HW_W-1];
        m_bit     = half[0];
        cmaj      = half[CMAJ_MSB:CMAJ_LSB];
        exempt    = (cmaj == CMAJ_W'(1)) || (cmaj == {CMAJ_W{1'b1}});
        entry_hit = (half[HW_W-1:OPC_LSB] == major_op);

        single   = 1'b0;
        fmt      = FMT_W32;
        nxt_mode = mode;

        case (mode)
            MODE_CMP: begin
                single = 1'b1;
                fmt    = (!exempt && n_bit && m_bit) ? FMT_CIMM : FMT_C16;
                if (!exempt) begin
                    case ({n_bit, m_bit})
                        2'b00:   nxt_mode = MODE_STD;
                        2'b10:   nxt_mode = MODE_ONE;
                        default: nxt_mode = MODE_CMP;
                    endcase
                end
            end
            MODE_STD: begin
                if (!pend && entry_hit) begin
                    single = 1'b1;
                    fmt    = FMT_C10;
                    if (!exempt && m_bit) begin
                        nxt_mode = MODE_CMP;
                    end
                end
            end
            MODE_ONE: begin
                if (pend) begin
                    nxt_mode = MODE_CMP;
                end
            end
            default: nxt_mode = MODE_STD;
        endcase
    end

endmodule

// File: rtl/cmseq_outreg.sv
module cmseq_outreg
    import cmseq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  fmt_e          load_fmt,
    input  logic          out_ready,
    output logic          free,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output fmt_e          out_fmt
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
        fmt_e          fmt;
    } oreg_t;

    oreg_t o_d;
    oreg_t o_q;

    always_comb begin
        o_d = o_q;
        if (flush) begin
            o_d.vld = 1'b0;
        end else if (load) begin
            o_d.vld  = 1'b1;
            o_d.data = load_data;
            o_d.fmt  = load_fmt;
        end else if (out_ready) begin
            o_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{vld: 1'b0, data: '0, fmt: FMT_W32};
        end else begin
            o_q <= o_d;
        end
    end

    assign free      = !o_q.vld || out_ready;
    assign out_valid = o_q.vld;
    assign out_data  = o_q.data;
    assign out_fmt   = o_q.fmt;

endmodule

// File: rtl/cmode_seq.sv
module cmode_seq
    import cmseq_pkg::*;
#(
    parameter int HW_W   = 16,
    parameter int OPC_W  = 5,
    parameter int CMAJ_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [OPC_W-1:0]  major_op,
    input  logic              in_valid,
    input  logic [HW_W-1:0]   in_half,
    output logic              in_ready,
    output logic              out_valid,
    output logic [2*HW_W-1:0] out_insn,
    output logic [1:0]        out_fmt,
    input  logic              out_ready
);

    localparam int IW = 2 * HW_W;

    typedef struct packed {
        mode_e           mode;
        logic            pend;
        logic [HW_W-1:0] hold;
    } seq_st_t;

    seq_st_t st_d;
    seq_st_t st_q;

    logic          cls_single;
    fmt_e          cls_fmt;
    mode_e         cls_nxt;
    logic          ob_free;
    logic          ob_load;
    logic [IW-1:0] ob_data;
    fmt_e          ob_fmt;
    fmt_e          ob_out_fmt;
    logic          accept;

    cmseq_classify #(
        .HW_W   (HW_W),
        .OPC_W  (OPC_W),
        .CMAJ_W (CMAJ_W)
    ) cls_i (
        .half     (in_half),
        .mode     (st_q.mode),
        .pend     (st_q.pend),
        .major_op (major_op),
        .single   (cls_single),
        .fmt      (cls_fmt),
        .nxt_mode (cls_nxt)
    );

    always_comb begin
        st_d     = st_q;
        ob_load  = 1'b0;
        ob_data  = '0;
        ob_fmt   = FMT_W32;
        in_ready = !flush && ob_free;
        accept   = in_valid && in_ready;

        if (flush) begin
            st_d.mode = MODE_STD;
            st_d.pend = 1'b0;
        end else if (accept) begin
            st_d.mode = cls_nxt;
            if (cls_single) begin
                ob_load = 1'b1;
                ob_data = {{HW_W{1'b0}}, in_half};
                ob_fmt  = cls_fmt;
            end else if (!st_q.pend) begin
                st_d.pend = 1'b1;
                st_d.hold = in_half;
            end else begin
                st_d.pend = 1'b0;
                ob_load   = 1'b1;
                ob_data   = {st_q.hold, in_half};
                ob_fmt    = FMT_W32;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_STD, pend: 1'b0, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    cmseq_outreg #(
        .DW (IW)
    ) oreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .load      (ob_load),
        .load_data (ob_data),
        .load_fmt  (ob_fmt),
        .out_ready (out_ready),
        .free      (ob_free),
        .out_valid (out_valid),
        .out_data  (out_insn),
        .out_fmt   (ob_out_fmt)
    );

    assign out_fmt = ob_out_fmt;

endmodule

// File: rtl/cmseq_chk.sv
module cmseq_chk #(
    parameter int HW_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [2*HW_W-1:0] out_insn,
    input logic [1:0]        out_fmt,
    input logic              out_ready
);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_insn) && $stable(out_fmt)));

    // R10
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R6
    imm_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt == 2'd3) |-> (out_insn[HW_W-1] && out_insn[0]));

    // R3
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt != 2'd0) |-> (out_insn[2*HW_W-1:HW_W] == '0));

    // R2
    origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

bind cmode_seq cmseq_chk #(.HW_W(HW_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_insn  (out_insn),
    .out_fmt   (out_fmt),
    .out_ready (out_ready)
);

// File: tb/cmode_seq_tb_top.sv
`timescale 1ns/1ps
module cmode_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [4:0]  major = 5'h1B;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_insn;
    logic [1:0]  out_fmt;
    logic        out_ready = 1'b1;

    always #2.5 clk = ~clk;

    cmode_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .major_op  (major),
        .in_valid  (in_valid),
        .in_half   (in_half),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_insn  (out_insn),
        .out_fmt   (out_fmt),
        .out_ready (out_ready)
    );

    typedef struct {
        logic [31:0] d;
        logic [1:0]  f;
    } exp_t;

    exp_t        q[$];
    int          vectors = 0;
    int          fails = 0;
    string       cur_req = "R1";
    int          m_mode = 0;   // 0: 32-bit, 1: 16-bit, 2: one 32-bit then back
    bit          m_pend = 0;
    logic [15:0] m_buf = '0;

    function automatic logic [15:0] hw(input logic [4:0] top, input logic [2:0] cm,
                                       input logic [6:0] mid, input logic m);
        return {top, cm, mid, m};
    endfunction

    task automatic model_step(input logic [15:0] h, output bit emit,
                              output logic [31:0] d, output logic [1:0] f);
        bit n;
        bit m;
        bit ex;
        n    = h[15];
        m    = h[0];
        ex   = (h[10:8] == 3'b001) || (h[10:8] == 3'b111);
        emit = 0;
        d    = '0;
        f    = 2'd0;
        if (m_mode == 1) begin
            emit = 1;
            d    = {16'h0, h};
            f    = (!ex && n && m) ? 2'd3 : 2'd2;
            if (!ex && !n && !m) m_mode = 0;
            if (!ex && n && !m)  m_mode = 2;
        end else if (m_mode == 0 && !m_pend && h[15:11] == major) begin
            emit = 1;
            d    = {16'h0, h};
            f    = 2'd1;
            if (!ex && m) m_mode = 1;
        end else if (!m_pend) begin
            m_pend = 1;
            m_buf  = h;
        end else begin
            m_pend = 0;
            emit   = 1;
            d      = {m_buf, h};
            f      = 2'd0;
            m_mode = (m_mode == 2) ? 1 : 0;
        end
    endtask

    task automatic cyc(input bit v, input logic [15:0] h, input bit r, input bit fl);
        bit          exp_v;
        bit          exp_rdy;
        bit          emit;
        logic [31:0] d;
        logic [1:0]  f;
        @(negedge clk);
        in_valid  = v;
        in_half   = h;
        out_ready = r;
        flush     = fl;
        #1;
        vectors++;
        exp_v   = (q.size() != 0);
        exp_rdy = !fl && (!exp_v || r);
        if (out_valid !== exp_v) begin
            fails++;
            $display("FAIL %s out_valid actual %b expected %b", cur_req, out_valid, exp_v);
        end else if (exp_v && (out_insn !== q[0].d || out_fmt !== q[0].f)) begin
            fails++;
            $display("FAIL %s out insn/fmt actual %h/%0d expected %h/%0d",
                     cur_req, out_insn, out_fmt, q[0].d, q[0].f);
        end
        if (in_ready !== exp_rdy) begin
            fails++;
            $display("FAIL %s in_ready actual %b expected %b", cur_req, in_ready, exp_rdy);
        end
        if (exp_v && r && !fl) void'(q.pop_front());
        if (fl) begin
            q.delete();
            m_mode = 0;
            m_pend = 0;
        end else if (v && exp_rdy) begin
            model_step(h, emit, d, f);
            if (emit) q.push_back('{d: d, f: f});
        end
    endtask

    task automatic put(input logic [15:0] h);
        cyc(1, h, 1, 0);
    endtask

    task automatic idle();
        cyc(0, 16'h0, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 out_valid in reset actual %b expected 0", out_valid);
        end
        rst_n = 1'b1;

        cur_req = "R1";
        idle();

        cur_req = "R2";
        put(16'h1234); put(16'h5678); idle();
        put(16'h9ABC); idle(); idle(); put(16'h4321); idle();

        cur_req = "R8";
        put(16'h1111); put(hw(5'h1B, 3'b010, 7'h15, 1'b1));
        put(16'h2222); put(16'h3333); idle();

        cur_req = "R3";
        put(hw(5'h1B, 3'b010, 7'h2A, 1'b0));
        put(16'h2468); put(16'h1357);
        put(hw(5'h1B, 3'b011, 7'h11, 1'b1));

        cur_req = "R4";
        put(hw(5'b00110, 3'b100, 7'h03, 1'b1));
        put(hw(5'b01010, 3'b101, 7'h40, 1'b1));

        cur_req = "R6";
        put(hw(5'b10101, 3'b010, 7'h7F, 1'b1));
        put(hw(5'b11111, 3'b110, 7'h01, 1'b1));

        cur_req = "R7";
        put(hw(5'b00000, 3'b001, 7'h12, 1'b0));
        put(hw(5'b10000, 3'b111, 7'h34, 1'b0));
        put(hw(5'b00011, 3'b010, 7'h00, 1'b1));

        cur_req = "R5";
        put(hw(5'b10011, 3'b100, 7'h05, 1'b0));
        put(hw(5'h1B, 3'b010, 7'h00, 1'b1));
        put(16'hCAFE);
        put(hw(5'b00001, 3'b110, 7'h22, 1'b1));

        cur_req = "R4";
        put(hw(5'b01100, 3'b101, 7'h0A, 1'b0));
        put(16'h0F0F); put(16'hF0F0); idle();

        cur_req = "R7";
        put(hw(5'h1B, 3'b001, 7'h3C, 1'b1));
        put(hw(5'h1B, 3'b111, 7'h3D, 1'b1));
        put(16'h1010); put(16'h2020); idle();

        cur_req = "R10";
        put(hw(5'h1B, 3'b010, 7'h00, 1'b0));
        cyc(1, 16'h3030, 0, 0); cyc(1, 16'h3030, 0, 0); cyc(1, 16'h3030, 0, 0);
        put(16'h3030); put(16'h4040);
        cyc(0, 16'h0, 0, 0); cyc(0, 16'h0, 0, 0); idle();

        cur_req = "R9";
        put(16'h5050);
        cyc(1, 16'hAAAA, 1, 1);
        put(16'h6060); put(16'h7070); idle();
        put(hw(5'h1B, 3'b010, 7'h00, 1'b1));
        cyc(1, hw(5'b00110, 3'b100, 7'h01, 1'b1), 0, 0);
        cyc(0, 16'h0, 0, 1);
        put(16'h8080); put(16'h9090); idle();

        cur_req = "R11";
        major = 5'h05;
        put(hw(5'h1B, 3'b010, 7'h00, 1'b1)); put(16'h1111);
        put(hw(5'h05, 3'b010, 7'h00, 1'b0)); idle();
        major = 5'h1B;
        idle();

        cur_req = "R10";
        for (int i = 0; i < 600; i++) begin
            logic [15:0] h;
            h = 16'($urandom);
            if ($urandom % 3 == 0) h[15:11] = major;
            cyc(($urandom % 4) != 0, h, ($urandom % 4) != 0, ($urandom % 50) == 0);
        end
        idle(); idle(); idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule